// File: doc/BRIEF.md
# Belief Convergence Stop Controller

This block sits beside the iteration loop of a message-passing multi-user detector and decides when the loop may stop. In every iteration the belief engine streams out its fixed set of `NB` beliefs, one per cycle. Each belief comes with the value that the same belief held in the previous iteration. For each pair the controller measures how far the belief moved relative to its old value. It returns the belief, rescaled if required, and records a per-belief stability flag. After the last beat of an iteration it either raises a one-cycle `done` or lets the engine run another pass.

A division-free test decides stability: the magnitude of the change is compared with the magnitude of the old value shifted right by `eps_shift`. In plain mode a stable belief only feeds the flags. In adaptive mode a belief that is still moving is pushed along its trend. A rising belief is grown by a shift-and-add factor above one and a falling belief is shrunk by a factor below one, so convergence speeds up. The first iteration has no meaningful previous value, so no comparison is made in it. The loop stops early once a whole iteration comes back stable; otherwise it stops at a programmable limit of at most `MAX_ITER` passes, for which three is a good working value.

Top module: `belief_stop_ctrl`

## Requirements
- R1: While reset is held and while no detection is active (before the first `start`), `out_valid`, `done` and `early` are 0, and beats offered with `in_valid` produce no output beat.
- R2: During a detection, each cycle with `in_valid`=1 and `start`=0 is one accepted beat. Each accepted beat gives exactly one output beat with `out_valid`=1 one clock later, and `iter_count` on that beat holds its 1-based iteration number. Beat number `NB` of an iteration closes the iteration.
- R3: In iteration 1 every output beat has `out_stable`=0 and `out_belief` equal to the input belief, in both modes.
- R4: With `adapt_en`=0, from iteration 2 on, `out_stable`=1 exactly when |V−P| ≤ (|P| >> `eps_shift`). `out_belief` equals V. V is `in_belief`, P is `in_prev`, and both are 16-bit two's complement.
- R5: With `adapt_en`=1, from iteration 2 on, `out_stable`=1 exactly when V=P or |V−P| < (|P| >> `eps_shift`). A stable belief is passed unchanged.
- R6: With `adapt_en`=1, from iteration 2 on, an unstable belief is rising when V−P has the sign of P (P=0 counts as positive) and falling otherwise. A rising belief becomes V + (V >>> `up_shift`), a falling one becomes V − (V >>> `down_shift`), using arithmetic shifts. The result saturates to [−32768, 32767].
- R7: Whether an iteration completes as all-stable is judged only from the flags of that iteration's own `NB` beats. Flags from earlier iterations never count.
- R8: When all `NB` beats of an iteration are stable, `done` and `early` are 1 for one cycle on the output beat of the last belief of that iteration, and the detection ends.
- R9: Otherwise `done`=1 with `early`=0 on the last output beat of the iteration whose number equals the limit. The limit is sampled from `iter_limit` at `start`; 0 acts as 1 and any value above `MAX_ITER` acts as `MAX_ITER`.
- R10: After `done`, beats are ignored until the next `start`. A `start` during a detection abandons it and begins again at iteration 1, belief 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new detection; samples `iter_limit` |
| in_valid | input | 1 | Belief beat present |
| in_belief | input | W | Current belief, signed |
| in_prev | input | W | Same belief in the previous iteration, signed |
| adapt_en | input | 1 | 1 = adaptive rescaling mode |
| eps_shift | input | SHW | Threshold as right-shift of the previous magnitude |
| up_shift | input | SHW | Growth step shift for rising beliefs |
| down_shift | input | SHW | Shrink step shift for falling beliefs |
| iter_limit | input | TW | Maximum iteration count |
| out_valid | output | 1 | Output beat present |
| out_belief | output | W | Belief after optional rescaling |
| out_stable | output | 1 | Stability flag of this belief |
| iter_count | output | TW | Iteration number of this output beat |
| done | output | 1 | Detection finished on this beat |
| early | output | 1 | Finish was caused by an all-stable iteration |

## Verification
Equal current and previous values in the first pass tell the skipped first comparison apart from a real test. Equal values in later passes exercise the early exit. Pairs placed exactly on the threshold, with both positive and negative old values, separate the inclusive plain-mode test from the strict adaptive one. An adaptive pass mixes rising and falling beliefs, sign crossings, a zero old value and values near full scale, which checks trend direction, both shift factors and saturation. Limits of 0 and above the maximum, a single unstable belief in an otherwise stable pass, beats offered with no detection running, and a restart mid-pass cover the loop control.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   typedef enum logic [1:0] {
      TREND_FLAT = 2'd0,
      TREND_RISE = 2'd1,
      TREND_FALL = 2'd2
   } trend_e;

   typedef struct packed {
      logic   stable;
      trend_e trend;
   } verdict_t;

endpackage

// File: rtl/bsc_judge.sv
module bsc_judge
   import bsc_pkg::*;
#(
   parameter int W        = 16,
   parameter int SHW      = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [W-1:0] cur,
   input  logic signed [W-1:0] prev,
   input  logic                first_pass,
   input  logic                adapt,
   input  logic [SHW-1:0]      eps_sh,
   input  logic [SHW-1:0]      up_sh,
   input  logic [SHW-1:0]      dn_sh,
   output logic signed [W-1:0] result,
   output logic                stable
);

   localparam int XW = W + 1;
   localparam logic signed [XW-1:0] HI = {2'b00, {(W-1){1'b1}}};
   localparam logic signed [XW-1:0] LO = {2'b11, {(W-1){1'b0}}};

   logic signed [XW-1:0] cur_x, prev_x, diff;
   logic        [XW-1:0] mag_diff, mag_prev, bound;
   logic                 plain_ok, adapt_ok;
   verdict_t             verdict;
   logic signed [XW-1:0] step_up, step_dn, grown, shrunk, pick;

   always_comb begin
      cur_x    = {cur[W-1], cur};
      prev_x   = {prev[W-1], prev};
      diff     = cur_x - prev_x;
      mag_diff = diff[XW-1] ? $unsigned(-diff) : $unsigned(diff);
      mag_prev = prev_x[XW-1] ? $unsigned(-prev_x) : $unsigned(prev_x);
      bound    = mag_prev >> eps_sh;
      plain_ok = (mag_diff <= bound);
      adapt_ok = (mag_diff == '0) || (mag_diff < bound);

      verdict.stable = !first_pass && (adapt ? adapt_ok : plain_ok);
      if (first_pass || !adapt || verdict.stable)
         verdict.trend = TREND_FLAT;
      else if (diff[XW-1] == prev[W-1])
         verdict.trend = TREND_RISE;
      else
         verdict.trend = TREND_FALL;

      step_up = cur_x >>> up_sh;
      step_dn = cur_x >>> dn_sh;
      grown   = cur_x + step_up;
      shrunk  = cur_x - step_dn;
      case (verdict.trend)
         TREND_RISE: pick = grown;
         TREND_FALL: pick = shrunk;
         default:    pick = cur_x;
      endcase
   end

   assign stable = verdict.stable;

   generate
      if (SATURATE) begin : g_clip
         always_comb begin
            if (pick > HI)
               result = HI[W-1:0];
            else if (pick < LO)
               result = LO[W-1:0];
            else
               result = pick[W-1:0];
         end
      end else begin : g_wrap
         always_comb result = pick[W-1:0];
      end
   endgenerate

endmodule

// File: rtl/bsc_flags.sv
module bsc_flags #(
   parameter int NB = 12,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          write,
   input  logic [IW-1:0] idx,
   input  logic          value,
   output logic          all_set
);

   logic [NB-1:0] flags;
   logic [NB-1:0] merged;

   generate
      for (genvar i = 0; i < NB; i++) begin : g_bit
         logic hit;
         assign hit       = write && (idx == IW'(i));
         assign merged[i] = hit ? value : flags[i];

         always_ff @(posedge clk) begin
            if (!rst_n)
               flags[i] <= 1'b0;
            else if (clear)
               flags[i] <= 1'b0;
            else if (hit)
               flags[i] <= value;
         end
      end
   endgenerate

   assign all_set = &merged;

endmodule

// File: rtl/bsc_seq.sv
module bsc_seq #(
   parameter int NB       = 12,
   parameter int MAX_ITER = 5,
   parameter int IW       = 4,
   parameter int TW       = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          in_valid,
   input  logic [TW-1:0] iter_limit,
   input  logic          all_set,
   output logic          beat,
   output logic          last,
   output logic [IW-1:0] idx,
   output logic [TW-1:0] iter,
   output logic          finish,
   output logic          early_hit
);

   localparam logic [TW-1:0] TOP_ITER = TW'(MAX_ITER);
   localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

   logic          busy;
   logic [TW-1:0] lim_q, lim_in;
   logic          at_limit;

   always_comb begin
      if (iter_limit == '0)
         lim_in = TW'(1);
      else if (iter_limit > TOP_ITER)
         lim_in = TOP_ITER;
      else
         lim_in = iter_limit;
   end

   assign beat      = busy && in_valid && !start;
   assign last      = (idx == LAST_IDX);
   assign at_limit  = (iter == lim_q);
   assign early_hit = beat && last && all_set;
   assign finish    = beat && last && (all_set || at_limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         iter  <= TW'(1);
         idx   <= '0;
         lim_q <= TW'(1);
      end else if (start) begin
         busy  <= 1'b1;
         iter  <= TW'(1);
         idx   <= '0;
         lim_q <= lim_in;
      end else if (beat) begin
         if (last) begin
            idx <= '0;
            if (finish)
               busy <= 1'b0;
            else
               iter <= iter + TW'(1);
         end else begin
            idx <= idx + IW'(1);
         end
      end
   end

endmodule

// File: rtl/belief_stop_ctrl.sv
module belief_stop_ctrl
   import bsc_pkg::*;
#(
   parameter int W        = 16,
   parameter int NB       = 12,
   parameter int MAX_ITER = 5,
   parameter int SHW      = 5,
   parameter bit SATURATE = 1'b1,
   localparam int TW      = $clog2(MAX_ITER + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_belief,
   input  logic signed [W-1:0] in_prev,
   input  logic                adapt_en,
   input  logic [SHW-1:0]      eps_shift,
   input  logic [SHW-1:0]      up_shift,
   input  logic [SHW-1:0]      down_shift,
   input  logic [TW-1:0]       iter_limit,
   output logic                out_valid,
   output logic signed [W-1:0] out_belief,
   output logic                out_stable,
   output logic [TW-1:0]       iter_count,
   output logic                done,
   output logic                early
);

   localparam int IW = $clog2(NB);

   initial begin : param_chk
      assert (W >= 4) else $fatal(1, "belief width too small");
      assert (NB >= 2) else $fatal(1, "need at least two beliefs per pass");
      assert (MAX_ITER >= 1) else $fatal(1, "iteration limit must be positive");
      assert ((1 << SHW) >= W) else $fatal(1, "shift fields cannot span the belief width");
   end

   logic                beat, last, finish, early_hit, all_set;
   logic [IW-1:0]       idx;
   logic [TW-1:0]       iter;
   logic signed [W-1:0] adj;
   logic                stable_now;

   bsc_seq #(
      .NB(NB), .MAX_ITER(MAX_ITER), .IW(IW), .TW(TW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .iter_limit(iter_limit), .all_set(all_set),
      .beat(beat), .last(last), .idx(idx), .iter(iter),
      .finish(finish), .early_hit(early_hit)
   );

   bsc_judge #(
      .W(W), .SHW(SHW), .SATURATE(SATURATE)
   ) u_judge (
      .cur(in_belief), .prev(in_prev),
      .first_pass(iter == TW'(1)), .adapt(adapt_en),
      .eps_sh(eps_shift), .up_sh(up_shift), .dn_sh(down_shift),
      .result(adj), .stable(stable_now)
   );

   bsc_flags #(
      .NB(NB), .IW(IW)
   ) u_flags (
      .clk(clk), .rst_n(rst_n),
      .clear(start || (beat && last)),
      .write(beat), .idx(idx), .value(stable_now),
      .all_set(all_set)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_belief <= '0;
         out_stable <= 1'b0;
         iter_count <= '0;
         done       <= 1'b0;
         early      <= 1'b0;
      end else begin
         out_valid <= beat;
         done      <= finish;
         early     <= early_hit;
         if (beat) begin
            out_belief <= adj;
            out_stable <= stable_now;
            iter_count <= iter;
         end
      end
   end

endmodule

// File: rtl/belief_stop_ctrl_chk.sv
module belief_stop_ctrl_chk #(
   parameter int W        = 16,
   parameter int MAX_ITER = 5,
   parameter int TW       = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic signed [W-1:0] in_belief,
   input logic                adapt_en,
   input logic                out_valid,
   input logic signed [W-1:0] out_belief,
   input logic                out_stable,
   input logic [TW-1:0]       iter_count,
   input logic                done,
   input logic                early
);

   // R2
   beat_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> !out_valid);

   // R2
   iter_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (iter_count >= TW'(1)) && (iter_count <= TW'(MAX_ITER)));

   // R3
   first_pass_unflagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && iter_count == TW'(1)) |-> !out_stable);

   // R4
   plain_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(!adapt_en)) |-> (out_belief == $past(in_belief)));

   // R8
   early_on_stable_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      early |-> (done && out_stable && out_valid));

   // R8
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind belief_stop_ctrl belief_stop_ctrl_chk #(
   .W(W), .MAX_ITER(MAX_ITER), .TW(TW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_belief(in_belief),
   .adapt_en(adapt_en), .out_valid(out_valid), .out_belief(out_belief),
   .out_stable(out_stable), .iter_count(iter_count), .done(done), .early(early)
);

// File: tb/sim_belief_stop_ctrl.sv
module sim_belief_stop_ctrl;

   localparam int W    = 16;
   localparam int NB   = 12;
   localparam int MAXI = 5;
   localparam int SHW  = 5;
   localparam int TW   = 3;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic                in_valid = 1'b0;
   logic signed [W-1:0] in_belief = '0;
   logic signed [W-1:0] in_prev = '0;
   logic                adapt_en = 1'b0;
   logic [SHW-1:0]      eps_shift = 5'd3;
   logic [SHW-1:0]      up_shift = 5'd1;
   logic [SHW-1:0]      down_shift = 5'd2;
   logic [TW-1:0]       iter_limit = 3'd3;
   logic                out_valid, out_stable, done, early;
   logic signed [W-1:0] out_belief;
   logic [TW-1:0]       iter_count;

   belief_stop_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_belief(in_belief), .in_prev(in_prev), .adapt_en(adapt_en),
      .eps_shift(eps_shift), .up_shift(up_shift), .down_shift(down_shift),
      .iter_limit(iter_limit), .out_valid(out_valid), .out_belief(out_belief),
      .out_stable(out_stable), .iter_count(iter_count), .done(done), .early(early)
   );

   always #2 clk = ~clk;

   int    checks = 0;
   int    fails = 0;
   int    cyc = 0;
   string scen_tag = "R1";
   string idle_tag = "R1";

   // reference model state
   bit m_busy = 0;
   int m_iter = 1, m_idx = 0, m_cnt = 0, m_lim = 1;
   bit exp_valid = 0, exp_stb = 0, exp_done = 0, exp_early = 0, exp_adapt = 0;
   int exp_bel = 0, exp_it = 0;
   int vb[NB];
   int vp[NB];

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int clip(int x);
      if (x > 32767) return 32767;
      if (x < -32768) return -32768;
      return x;
   endfunction

   function automatic int absv(int x);
      return (x < 0) ? -x : x;
   endfunction

   task automatic predict(int v, int p, int it, output int ov, output bit st);
      int d, thr;
      bit rise;
      ov = v;
      st = 0;
      if (it == 1) return;
      d   = v - p;
      thr = absv(p) >> int'(eps_shift);
      if (!adapt_en) begin
         st = (absv(d) <= thr);
      end else if (d == 0 || absv(d) < thr) begin
         st = 1;
      end else begin
         rise = (p >= 0) ? (d > 0) : (d < 0);
         if (rise) ov = clip(v + (v >>> int'(up_shift)));
         else      ov = clip(v - (v >>> int'(down_shift)));
      end
   endtask

   task automatic cycle(bit s, bit iv, int v, int p);
      int ov;
      bit st;
      string tb_tag;
      @(negedge clk);
      // compare outputs produced by the previous edge
      chk(exp_valid ? "R2" : idle_tag, "out_valid", int'(out_valid), int'(exp_valid));
      chk(scen_tag, "done", int'(done), int'(exp_done));
      if (exp_valid) begin
         tb_tag = (exp_it == 1) ? "R3" : (exp_adapt ? "R5" : "R4");
         chk(tb_tag, "out_stable", int'(out_stable), int'(exp_stb));
         if (exp_it != 1 && exp_adapt && !exp_stb) tb_tag = "R6";
         chk(tb_tag, "out_belief", int'(out_belief), exp_bel);
         chk("R2", "iter_count", int'(iter_count), exp_it);
         chk("R8", "early", int'(early), int'(exp_early));
      end
      // drive next inputs
      start     = s;
      in_valid  = iv;
      in_belief = W'(v);
      in_prev   = W'(p);
      exp_valid = 0;
      exp_done  = 0;
      exp_early = 0;
      if (!rst_n) begin
         m_busy = 0;
      end else if (s) begin
         m_busy = 1; m_iter = 1; m_idx = 0; m_cnt = 0;
         m_lim = (iter_limit == 0) ? 1 : (int'(iter_limit) > MAXI ? MAXI : int'(iter_limit));
      end else if (m_busy && iv) begin
         predict(v, p, m_iter, ov, st);
         exp_valid = 1; exp_bel = ov; exp_stb = st; exp_it = m_iter; exp_adapt = adapt_en;
         if (st) m_cnt++;
         if (m_idx == NB - 1) begin
            exp_early = (m_cnt == NB);
            exp_done  = exp_early || (m_iter == m_lim);
            if (exp_done) m_busy = 0;
            else m_iter++;
            m_idx = 0; m_cnt = 0;
         end else begin
            m_idx++;
         end
      end
   endtask

   task automatic send_iter();
      for (int i = 0; i < NB; i++) cycle(0, 1, vb[i], vp[i]);
   endtask

   task automatic kick();
      cycle(1, 0, 0, 0);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle(0, 0, 0, 0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++;
         fails++;
         $display("FAIL R2 watchdog: actual %0d cycles expected fewer than 20000", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1: beats with no detection running
      for (int i = 0; i < NB; i++) begin vb[i] = 50 * i; vp[i] = 50 * i; end
      send_iter();
      idle(2);

      // R8 with R3/R4: plain mode, equal values settle in pass two
      scen_tag = "R8"; adapt_en = 0; eps_shift = 3; iter_limit = 3;
      kick();
      for (int i = 0; i < NB; i++) begin vb[i] = 100 * (i + 1); vp[i] = vb[i]; end
      send_iter();
      send_iter();
      idle(2);

      // R9 with R4 threshold boundary: one belief stays just outside
      scen_tag = "R9";
      kick();
      for (int i = 0; i < NB; i++) begin
         vp[i] = (i % 2) ? -800 : 800;
         vb[i] = (i % 2) ? -900 : 900;
      end
      vp[5] = 800; vb[5] = 901;
      for (int k = 0; k < 3; k++) send_iter();
      idle(2);

      // R7: completion judged per pass only
      scen_tag = "R7"; iter_limit = 4;
      kick();
      for (int i = 0; i < NB; i++) begin vp[i] = 800; vb[i] = 800; end
      send_iter();
      vb[NB-1] = 1300;
      send_iter();
      vb[NB-1] = 800; vb[0] = 1300;
      send_iter();
      vb[0] = 800;
      send_iter();
      idle(2);

      // R5/R6: adaptive rescaling, trends, saturation
      scen_tag = "R9"; adapt_en = 1; eps_shift = 3; up_shift = 1; down_shift = 2; iter_limit = 2;
      vp[0] = 800;    vb[0] = 900;
      vp[1] = 800;    vb[1] = 700;
      vp[2] = -800;   vb[2] = -900;
      vp[3] = -800;   vb[3] = -700;
      vp[4] = 30000;  vb[4] = 31000;
      vp[5] = 20000;  vb[5] = 30000;
      vp[6] = -20000; vb[6] = -30000;
      vp[7] = 0;      vb[7] = 0;
      vp[8] = 0;      vb[8] = 5;
      vp[9] = 100;    vb[9] = 103;
      vp[10] = 1000;  vb[10] = -1000;
      vp[11] = -1000; vb[11] = 1000;
      kick();
      send_iter();
      send_iter();
      idle(2);

      // R9: limit clamping, 0 acts as 1 and 7 acts as MAXI
      adapt_en = 0; iter_limit = 0;
      for (int i = 0; i < NB; i++) begin vp[i] = 500; vb[i] = 1500; end
      kick();
      send_iter();
      idle(2);
      iter_limit = 7;
      kick();
      for (int k = 0; k < 5; k++) send_iter();
      idle(2);

      // R10: ignored after done, then restart in the middle of a pass
      idle_tag = "R10"; scen_tag = "R10";
      send_iter();
      idle(2);
      iter_limit = 2;
      for (int i = 0; i < NB; i++) begin vp[i] = 700 - 30 * i; vb[i] = vp[i]; end
      kick();
      for (int i = 0; i < 5; i++) cycle(0, 1, vb[i], vp[i]);
      kick();
      send_iter();
      send_iter();
      idle(3);

      summary();
      $finish;
   end

endmodule